// File: doc/BRIEF.md
# Parallel Instruction Boundary Splitter for Mixed 16/32-bit Code

The block takes one fetched window of code in which 16-bit compressed instructions and 32-bit instructions are freely mixed, and splits it into separate instructions within a single cycle. The window is cut into aligned 32-bit parcels. Each parcel is handled by an identical slice, which can also see the halfword just before its parcel. A single "unaligned" bit ripples from slice to slice. It tells the next slice that its first halfword finishes a 32-bit instruction that began in the previous parcel.

Each slice emits up to two instruction slots. The first slot always holds an instruction. It is either a 32-bit instruction that began in the previous halfword, a 32-bit instruction aligned to the parcel, or a 16-bit instruction. The second slot, when it is filled, holds a 16-bit instruction taken from the upper half of the parcel.

Two pieces of state are registered and fed to slice 0 on the next accepted fetch: the unaligned bit leaving the last slice, and the upper halfword of the last parcel. This lets a 32-bit instruction straddle two fetch words. A flush input clears that state, for example after a redirect.

Top module: `isplit_top`

## Requirements
- R1: An instruction is 32 bits wide exactly when bits [1:0] of its first halfword are 2'b11. Any other value marks a 16-bit instruction, which is presented in a slot with data bits [31:16] zero and its wide flag low.
- R2: With the incoming unaligned bit clear and parcel bits [1:0] = 2'b11, the slice's first slot holds the whole parcel as one 32-bit instruction. Its second slot is empty.
- R3: With the incoming unaligned bit clear and a 16-bit instruction at the parcel's low half, the first slot holds that 16-bit instruction. If bits [17:16] are not 2'b11, the second slot holds the 16-bit instruction in bits [31:16]. Otherwise the second slot is empty and the unaligned bit is passed on.
- R4: With the incoming unaligned bit set, the first slot holds the 32-bit instruction {parcel[15:0], preceding halfword}. The second slot then behaves as in R3 on bits [31:16]. The preceding halfword never appears as an instruction of its own.
- R5: Output slot 2i is the first slot of slice i and slot 2i+1 is its second slot, so the slots are in program order. While a fetch is presented, every even slot is valid and every valid odd slot is a 16-bit instruction.
- R6: While fetch_valid is low, no slot is valid.
- R7: The unaligned bit of the last slice and bits [127:112] of the fetch word are captured only on a cycle with fetch_valid high. On the next fetch they act as slice 0's incoming unaligned bit and preceding halfword, also after idle cycles in between.
- R8: Reset and flush clear the captured state, so the next fetch begins with a fresh instruction at byte 0.
- R9: A 128-bit fetch word yields between 4 and 8 valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clears the carried unaligned state |
| fetch_valid | input | 1 | A fetch word is presented this cycle |
| fetch_data | input | 128 | Fetch word, byte 0 in bits [7:0] |
| slot_valid | output | 8 | Slot holds an instruction |
| slot_wide | output | 8 | Slot instruction is 32 bits |
| slot_data | output | 256 | Slot k in bits [32k+31:32k] |

## Verification
The bench builds the block with its default of four slices. At that size the unaligned bit crosses all three inner slice boundaries and also the registered boundary between fetch words. Directed words place 32-bit instructions across every one of those boundaries, and they also exercise the all-narrow and all-aligned extremes of R9. Every result is compared with a halfword-by-halfword length walk kept in the bench. That walk also covers random streams, flush, and idle gaps while a straddle is pending.

// File: rtl/isplit_pkg.sv
package isplit_pkg;

    typedef struct packed {
        logic        valid;
        logic        wide;
        logic [31:0] data;
    } slot_t;

    function automatic logic starts_wide(input logic [15:0] hw);
        return hw[1:0] == 2'b11;
    endfunction

endpackage

// File: rtl/isplit_slice.sv
module isplit_slice
    import isplit_pkg::*;
(
    input  logic        carry_in,
    input  logic [15:0] prev_hw,
    input  logic [31:0] parcel,
    output slot_t       first_o,
    output slot_t       second_o,
    output logic        carry_o
);
    logic upper_starts;

    always_comb begin
        // first slot: straddled 32-bit, aligned 32-bit, or 16-bit
        first_o.valid = 1'b1;
        if (carry_in) begin
            first_o.wide = 1'b1;
            first_o.data = {parcel[15:0], prev_hw};
        end else if (starts_wide(parcel[15:0])) begin
            first_o.wide = 1'b1;
            first_o.data = parcel;
        end else begin
            first_o.wide = 1'b0;
            first_o.data = {16'h0000, parcel[15:0]};
        end

        // upper halfword begins an instruction unless covered by an aligned 32-bit one
        upper_starts    = carry_in | ~starts_wide(parcel[15:0]);
        second_o.valid  = upper_starts & ~starts_wide(parcel[31:16]);
        second_o.wide   = 1'b0;
        second_o.data   = {16'h0000, parcel[31:16]};
        carry_o         = upper_starts & starts_wide(parcel[31:16]);
    end

endmodule

// File: rtl/isplit_carry_reg.sv
module isplit_carry_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        load,
    input  logic        carry_in,
    input  logic [15:0] hw_in,
    output logic        carry_q,
    output logic [15:0] hw_q
);
    typedef struct packed {
        logic        carry;
        logic [15:0] hw;
    } carry_state_t;

    carry_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = '0;
        end else if (load) begin
            state_d.carry = carry_in;
            state_d.hw    = hw_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign carry_q = state_q.carry;
    assign hw_q    = state_q.hw;

endmodule

// File: rtl/isplit_top.sv
module isplit_top
    import isplit_pkg::*;
#(
    parameter int NUM_SLICES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       fetch_valid,
    input  logic [32*NUM_SLICES-1:0]   fetch_data,
    output logic [2*NUM_SLICES-1:0]    slot_valid,
    output logic [2*NUM_SLICES-1:0]    slot_wide,
    output logic [64*NUM_SLICES-1:0]   slot_data
);
    localparam int FETCH_W   = 32 * NUM_SLICES;
    localparam int NUM_SLOTS = 2 * NUM_SLICES;

    logic [NUM_SLICES:0] carry_chain;
    logic                carry_q;
    logic [15:0]         hw_q;
    slot_t               first_s  [NUM_SLICES];
    slot_t               second_s [NUM_SLICES];

    assign carry_chain[0] = carry_q;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        logic [15:0] prev_hw;
        if (i == 0) begin : g_head
            assign prev_hw = hw_q;
        end else begin : g_body
            assign prev_hw = fetch_data[32*i-1 -: 16];
        end

        isplit_slice i_slice (
            .carry_in (carry_chain[i]),
            .prev_hw  (prev_hw),
            .parcel   (fetch_data[32*i +: 32]),
            .first_o  (first_s[i]),
            .second_o (second_s[i]),
            .carry_o  (carry_chain[i+1])
        );

        assign slot_valid[2*i]          = fetch_valid & first_s[i].valid;
        assign slot_wide[2*i]           = first_s[i].wide;
        assign slot_data[64*i +: 32]    = first_s[i].data;
        assign slot_valid[2*i+1]        = fetch_valid & second_s[i].valid;
        assign slot_wide[2*i+1]         = second_s[i].wide;
        assign slot_data[64*i+32 +: 32] = second_s[i].data;
    end

    isplit_carry_reg i_carry_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .load     (fetch_valid),
        .carry_in (carry_chain[NUM_SLICES]),
        .hw_in    (fetch_data[FETCH_W-1 -: 16]),
        .carry_q  (carry_q),
        .hw_q     (hw_q)
    );

    logic unused_ok;
    assign unused_ok = ^NUM_SLOTS;

endmodule

// File: rtl/isplit_checker.sv
module isplit_checker #(
    parameter int NUM_SLICES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush,
    input logic                     fetch_valid,
    input logic [32*NUM_SLICES-1:0] fetch_data,
    input logic [2*NUM_SLICES-1:0]  slot_valid,
    input logic [2*NUM_SLICES-1:0]  slot_wide,
    input logic [64*NUM_SLICES-1:0] slot_data
);
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_chk
        assert_first_filled_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_valid |-> slot_valid[2*i]);
        assert_second_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[2*i+1] |-> !slot_wide[2*i+1]);
    end

    for (genvar k = 0; k < 2*NUM_SLICES; k++) begin : g_ext
        assert_narrow_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[k] && !slot_wide[k]) |-> (slot_data[32*k+16 +: 16] == 16'h0000));
    end

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (slot_valid == '0));

    assert_count_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ($countones(slot_valid) >= NUM_SLICES));

    assert_fresh_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && fetch_valid) |->
            (slot_data[31:0] == ((fetch_data[1:0] == 2'b11) ? fetch_data[31:0]
                                                             : {16'h0000, fetch_data[15:0]})));
endmodule

bind isplit_top isplit_checker #(.NUM_SLICES(NUM_SLICES)) i_isplit_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fetch_valid (fetch_valid),
    .fetch_data  (fetch_data),
    .slot_valid  (slot_valid),
    .slot_wide   (slot_wide),
    .slot_data   (slot_data)
);

// File: tb/test_isplit_top.sv
module test_isplit_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NSLOT = 2 * NS;
    localparam int NHW = 2 * NS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 flush = 1'b0;
    logic                 fetch_valid = 1'b0;
    logic [32*NS-1:0]     fetch_data = '0;
    logic [NSLOT-1:0]     slot_valid;
    logic [NSLOT-1:0]     slot_wide;
    logic [64*NS-1:0]     slot_data;

    int checks = 0;
    int errors = 0;

    // bench model of the carried state
    logic        m_pend = 1'b0;
    logic [15:0] m_hw = '0;

    logic        e_valid [NSLOT];
    logic        e_wide  [NSLOT];
    logic [31:0] e_data  [NSLOT];

    isplit_top #(.NUM_SLICES(NS)) i_isplit_top (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .slot_valid(slot_valid), .slot_wide(slot_wide),
        .slot_data(slot_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // sequential length walk over halfwords
    task automatic model(input logic [32*NS-1:0] w, output logic nxt_pend, output logic [15:0] nxt_hw);
        int k;
        for (int s = 0; s < NSLOT; s++) begin
            e_valid[s] = 1'b0; e_wide[s] = 1'b0; e_data[s] = '0;
        end
        k = 0;
        nxt_pend = 1'b0;
        nxt_hw = w[32*NS-1 -: 16];
        if (m_pend) begin
            e_valid[0] = 1'b1; e_wide[0] = 1'b1; e_data[0] = {w[15:0], m_hw};
            k = 1;
        end
        while (k < NHW) begin
            logic [15:0] h;
            h = w[16*k +: 16];
            if (h[1:0] == 2'b11) begin
                if (k == NHW - 1) begin
                    nxt_pend = 1'b1;
                    k = k + 1;
                end else begin
                    int s;
                    s = (k % 2 == 0) ? k : k + 1;
                    e_valid[s] = 1'b1; e_wide[s] = 1'b1;
                    e_data[s] = {w[16*(k+1) +: 16], h};
                    k = k + 2;
                end
            end else begin
                e_valid[k] = 1'b1; e_wide[k] = 1'b0; e_data[k] = {16'h0, h};
                k = k + 1;
            end
        end
    endtask

    task automatic fetch(input string tag, input logic [32*NS-1:0] w);
        logic np;
        logic [15:0] nh;
        int cnt;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_data = w;
        model(w, np, nh);
        #1;
        cnt = 0;
        for (int s = 0; s < NSLOT; s++) begin
            check($sformatf("%s slot%0d valid", tag, s), 64'(slot_valid[s]), 64'(e_valid[s]));
            if (e_valid[s]) begin
                cnt++;
                check($sformatf("%s slot%0d wide", tag, s), 64'(slot_wide[s]), 64'(e_wide[s]));
                check($sformatf("%s slot%0d data", tag, s), 64'(slot_data[32*s +: 32]), 64'(e_data[s]));
            end
        end
        checks++;
        if (cnt < NS || cnt > NSLOT) begin
            errors++;
            $display("FAIL R9 count: actual=%0d expected=4..8", cnt);
        end
        @(posedge clk);
        m_pend = np;
        m_hw = nh;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    function automatic logic [15:0] nar(input logic [13:0] v);
        return {v, 2'b00};
    endfunction
    function automatic logic [15:0] wid(input logic [13:0] v);
        return {v, 2'b11};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R6 idle no slots", 64'(slot_valid), 64'(0));
        check("R8 reset clears carry (idle)", 64'(slot_valid), 64'(0));
        fetch("R8 first after reset", {wid(14'h1), nar(14'h2), nar(14'h3), nar(14'h4),
                                       nar(14'h5), nar(14'h6), nar(14'h7), wid(14'h8)});
    endtask

    task automatic t_all_narrow();
        logic [32*NS-1:0] w;
        for (int k = 0; k < NHW; k++) w[16*k +: 16] = nar(14'(k * 37 + 5));
        fetch("R1 R3 all narrow", w);
    endtask

    task automatic t_all_aligned();
        logic [32*NS-1:0] w;
        for (int k = 0; k < NHW; k++)
            w[16*k +: 16] = (k % 2 == 0) ? wid(14'(k + 100)) : 16'(k * 4099 + 3);
        fetch("R2 all aligned wide", w);
    endtask

    task automatic t_straddle();
        logic [32*NS-1:0] w;
        w[15:0] = nar(14'h11);
        for (int k = 1; k < NHW; k += 2) begin
            w[16*k +: 16] = wid(14'(k));
            if (k + 1 < NHW) w[16*(k+1) +: 16] = 16'(16'hA000 + k);
        end
        fetch("R4 straddle every slice", w);
        for (int k = 0; k < NHW; k++) w[16*k +: 16] = nar(14'(k + 60));
        w[15:0] = 16'hBEEF;
        fetch("R7 straddle fetch words", w);
    endtask

    task automatic t_idle_hold();
        logic [32*NS-1:0] w;
        for (int k = 0; k < NHW; k++) w[16*k +: 16] = nar(14'(k + 200));
        w[16*(NHW-1) +: 16] = wid(14'h3AB);
        fetch("R3 carry out of last", w);
        repeat (3) @(negedge clk);
        check("R6 idle while pending", 64'(slot_valid), 64'(0));
        for (int k = 0; k < NHW; k++) w[16*k +: 16] = wid(14'(k));
        w[15:0] = 16'h1234;
        fetch("R7 hold across idle", w);
    endtask

    task automatic t_flush();
        logic [32*NS-1:0] w;
        for (int k = 0; k < NHW; k++) w[16*k +: 16] = nar(14'(k + 300));
        w[16*(NHW-1) +: 16] = wid(14'h155);
        fetch("R7 set pending", w);
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        m_pend = 1'b0;
        m_hw = '0;
        @(negedge clk);
        flush = 1'b0;
        for (int k = 0; k < NHW; k++) w[16*k +: 16] = nar(14'(k + 400));
        fetch("R8 flush drops straddle", w);
    endtask

    task automatic t_random();
        logic [32*NS-1:0] w;
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < NHW; k++) begin
                logic [15:0] r;
                r = 16'($urandom);
                if (n % 3 == 0) r[1:0] = 2'b11;
                w[16*k +: 16] = r;
            end
            fetch("R5 random mix", w);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_narrow();
        t_all_aligned();
        t_straddle();
        t_idle_hold();
        t_flush();
        t_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule